// File: doc/BRIEF.md
# Byte-Addressed Serial Register Slave with Paged Non-Volatile Commit

This block is the two-wire serial front end of a register-mapped device. It watches SCL and SDA, which are brought into the system clock domain through flop synchronizers, and answers to a 7-bit device address. Five of the address bits are fixed. The other two come from board strap pins, so four devices can share one bus. Once the block has matched its address, it steers an 8-bit address counter. In a write, the first byte after the device byte loads that counter and each later byte is stored at the counter. In a read, bytes are returned from the counter. The counter advances after every byte. Register contents live outside the block and are reached through a simple write-strobe and read-address port.

Part of the register space is backed by a non-volatile copy. Bytes written to those locations are also held in a page buffer with one slot for each of 8 consecutive addresses. A STOP that closes a write with buffered bytes starts a timed commit. When the timer runs out, the buffered bytes are handed to the non-volatile store one at a time. For the whole commit the block refuses its own address, so a host can poll with the device byte until the block acknowledges again. A host that ends a write with a repeated START keeps the register changes and discards the buffered copy. An input bit decides whether writes to location 00h also reach the non-volatile copy.

Top module: `i2c_page_slave`

## Requirements
- R1: After reset, sda_oe_o and busy_o are low and neither reg_we_o nor nv_we_o pulses until a transfer happens.
- R2: After a START, the first byte is taken MSB first as {01010, strap_i[1], strap_i[0], rw}, with rw=0 meaning write and rw=1 meaning read. On a match while not busy, the block pulls SDA low (sda_oe_o=1) in the 9th bit. On a mismatch it leaves SDA released there and ignores every following bit until the next START.
- R3: In a write, the second byte loads the address counter. Each further byte is acknowledged, and during its ACK bit it produces one single-cycle reg_we_o pulse carrying the counter as reg_addr_o and the byte as reg_wdata_o.
- R4: During a write, the address counter steps only in its low 3 bits while bits 7:3 stay fixed. The ninth data byte therefore returns to the start of the same 8-byte page and overwrites it.
- R5: In a read, bytes are shifted out MSB first from the location at reg_raddr_o, starting at the current counter. The counter steps by one per byte over the full range, so FFh is followed by 00h. A master ACK continues the read. A master NACK makes the block release SDA until the next START.
- R6: Locations 00h, 03h and 80h–C7h are non-volatile. A write to any of them also fills the page slot given by address bits 2:0, and the last byte written to a slot wins. A STOP after at least one buffered byte raises busy_o the cycle after the STOP is seen. After COMMIT_CYCLES cycles, nv_we_o pulses once per filled slot in ascending slot order with the full address and data. busy_o then falls.
- R7: A repeated START that follows buffered writes discards the buffer, so the later STOP starts no commit and no nv_we_o pulse appears.
- R8: While busy_o is high, the block does not acknowledge its own device byte and makes no register write.
- R9: With shadow_only_i=1, a write to 00h produces its reg_we_o pulse but is kept out of the page buffer. With shadow_only_i=0, the same write is also committed.
- R10: A STOP that closes a write touching only volatile locations leaves busy_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open-drain) |
| strap_i | input | 2 | Device address bits 2:1 from board straps |
| shadow_only_i | input | 1 | 1: writes to 00h bypass the non-volatile copy |
| reg_we_o | output | 1 | Register write strobe, one cycle |
| reg_addr_o | output | 8 | Register write address |
| reg_wdata_o | output | 8 | Register write data |
| reg_raddr_o | output | 8 | Register read address (address counter) |
| reg_rdata_i | input | 8 | Register read data for reg_raddr_o |
| busy_o | output | 1 | Non-volatile commit in progress |
| nv_we_o | output | 1 | Non-volatile write strobe |
| nv_addr_o | output | 8 | Non-volatile write address |
| nv_wdata_o | output | 8 | Non-volatile write data |

## Verification
The bench writes ten bytes into one non-volatile page. A design that let the counter carry into bit 3 would strobe 88h and 89h and commit the wrong slot contents. A read that starts at FEh must come back through 00h, which catches a counter that wraps inside a page on reads too. The bench polls the device address during a commit; a block that acknowledged there would accept a write whose copy could never be committed. Two further cases target the page buffer: a write closed by a repeated START, which would set busy_o if the buffer were not dropped, and a 00h write with the shadow bit set, which would produce an extra non-volatile strobe if the filter were wrong. A mismatched device byte is followed by data bytes, and any register strobe seen there shows the block failed to ignore the bus.

// File: rtl/i2c_ps_pkg.sv
package i2c_ps_pkg;
  localparam int unsigned ADDR_W = 8;

  typedef enum logic [2:0] {PH_IDLE, PH_DEV, PH_MEM, PH_WR, PH_RD, PH_SKIP} phase_e;
  typedef enum logic [1:0] {CM_OPEN, CM_WAIT, CM_DRAIN} commit_e;

  function automatic logic nv_loc(input logic [ADDR_W-1:0] a, input logic [7:0] row0_mask,
                                  input logic [ADDR_W-1:0] lo, input logic [ADDR_W-1:0] hi);
    return ((a[ADDR_W-1:3] == '0) && row0_mask[a[2:0]]) || ((a >= lo) && (a <= hi));
  endfunction
endpackage

// File: rtl/i2c_ps_sync.sv
module i2c_ps_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] raw, synced;
  logic              scl_q, sda_q;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= synced[1];
      sda_q <= synced[0];
    end
  end

  assign scl_o      = synced[1];
  assign sda_o      = synced[0];
  assign scl_rise_o = synced[1] & ~scl_q;
  assign scl_fall_o = ~synced[1] & scl_q;
  // SDA edge while SCL stays high
  assign start_o    = synced[1] & scl_q & sda_q & ~synced[0];
  assign stop_o     = synced[1] & scl_q & ~sda_q & synced[0];
endmodule

// File: rtl/i2c_ps_engine.sv
module i2c_ps_engine
  import i2c_ps_pkg::*;
#(
  parameter logic [4:0]  DEV_PREFIX = 5'b01010,
  parameter int unsigned PAGE_AW    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        strap_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] rdata_i,
  output logic              sda_oe_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] raddr_o
);
  phase_e            phase_q;
  logic [3:0]        cnt_q;
  logic [7:0]        shreg_q;
  logic [6:0]        tx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rw_q, mack_q;

  assign raddr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      shreg_q  <= '0;
      tx_q     <= '0;
      addr_q   <= '0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      sda_oe_o <= 1'b0;
      we_o     <= 1'b0;
      waddr_o  <= '0;
      wdata_o  <= '0;
    end else begin
      we_o <= 1'b0;
      if (start_i) begin
        phase_q  <= PH_DEV;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        phase_q  <= PH_IDLE;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (phase_q == PH_IDLE || phase_q == PH_SKIP) begin
        cnt_q <= '0;
      end else if (scl_rise_i) begin
        if (cnt_q < 4'd8) shreg_q <= {shreg_q[6:0], sda_i};
        else              mack_q  <= ~sda_i;
        cnt_q <= cnt_q + 4'd1;
      end else if (scl_fall_i) begin
        if (cnt_q == 4'd8) begin
          // byte complete: drive or release the 9th bit
          unique case (phase_q)
            PH_DEV: begin
              if (shreg_q[7:1] == {DEV_PREFIX, strap_i} && !busy_i) begin
                sda_oe_o <= 1'b1;
                rw_q     <= shreg_q[0];
              end else begin
                phase_q <= PH_SKIP;
              end
            end
            PH_MEM: begin
              sda_oe_o <= 1'b1;
              addr_q   <= shreg_q;
            end
            PH_WR: begin
              sda_oe_o <= 1'b1;
              we_o     <= 1'b1;
              waddr_o  <= addr_q;
              wdata_o  <= shreg_q;
              addr_q   <= {addr_q[ADDR_W-1:PAGE_AW], addr_q[PAGE_AW-1:0] + 1'b1};
            end
            PH_RD:   sda_oe_o <= 1'b0;
            default: ;
          endcase
        end else if (cnt_q == 4'd9) begin
          cnt_q    <= '0;
          sda_oe_o <= 1'b0;
          unique case (phase_q)
            PH_DEV: begin
              if (rw_q) begin
                phase_q  <= PH_RD;
                tx_q     <= rdata_i[6:0];
                sda_oe_o <= ~rdata_i[7];
                addr_q   <= addr_q + 1'b1;
              end else begin
                phase_q <= PH_MEM;
              end
            end
            PH_MEM: phase_q <= PH_WR;
            PH_RD: begin
              if (mack_q) begin
                tx_q     <= rdata_i[6:0];
                sda_oe_o <= ~rdata_i[7];
                addr_q   <= addr_q + 1'b1;
              end else begin
                phase_q <= PH_SKIP;
              end
            end
            default: ;
          endcase
        end else if (phase_q == PH_RD && cnt_q != 4'd0) begin
          sda_oe_o <= ~tx_q[6];
          tx_q     <= {tx_q[5:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/i2c_ps_page.sv
module i2c_ps_page
  import i2c_ps_pkg::*;
#(
  parameter int unsigned       PAGE_BYTES    = 8,
  parameter int unsigned       COMMIT_CYCLES = 2_500_000,
  parameter logic [7:0]        NV_ROW0_MASK  = 8'h09,
  parameter logic [ADDR_W-1:0] NV_LO         = 8'h80,
  parameter logic [ADDR_W-1:0] NV_HI         = 8'hC7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              shadow_only_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              busy_o,
  output logic              nv_we_o,
  output logic [ADDR_W-1:0] nv_addr_o,
  output logic [ADDR_W-1:0] nv_wdata_o
);
  localparam int unsigned PAGE_AW = $clog2(PAGE_BYTES);
  localparam int unsigned TW      = (COMMIT_CYCLES > 1) ? $clog2(COMMIT_CYCLES) : 1;

  commit_e                        st_q;
  logic [PAGE_BYTES-1:0][7:0]     buf_q;
  logic [PAGE_BYTES-1:0]          vld_q;
  logic [ADDR_W-PAGE_AW-1:0]      base_q;
  logic [PAGE_AW-1:0]             slot_q;
  logic [TW-1:0]                  tmr_q;
  logic                           take;

  assign take = we_i && nv_loc(waddr_i, NV_ROW0_MASK, NV_LO, NV_HI)
                && !(shadow_only_i && waddr_i == '0);

  always_ff @(posedge clk_i) begin
    if (st_q == CM_OPEN && take) buf_q[waddr_i[PAGE_AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CM_OPEN;
      vld_q  <= '0;
      base_q <= '0;
      slot_q <= '0;
      tmr_q  <= '0;
    end else begin
      unique case (st_q)
        CM_OPEN: begin
          if (start_i) begin
            vld_q <= '0;  // repeated START drops the page
          end else if (stop_i && |vld_q) begin
            st_q  <= CM_WAIT;
            tmr_q <= TW'(COMMIT_CYCLES - 1);
          end else if (take) begin
            vld_q[waddr_i[PAGE_AW-1:0]] <= 1'b1;
            base_q <= waddr_i[ADDR_W-1:PAGE_AW];
          end
        end
        CM_WAIT: begin
          if (tmr_q == '0) begin
            st_q   <= CM_DRAIN;
            slot_q <= '0;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        CM_DRAIN: begin
          if (slot_q == PAGE_AW'(PAGE_BYTES - 1)) begin
            st_q  <= CM_OPEN;
            vld_q <= '0;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        default: st_q <= CM_OPEN;
      endcase
    end
  end

  assign busy_o     = (st_q != CM_OPEN);
  assign nv_we_o    = (st_q == CM_DRAIN) && vld_q[slot_q];
  assign nv_addr_o  = {base_q, slot_q};
  assign nv_wdata_o = buf_q[slot_q];
endmodule

// File: rtl/i2c_page_slave.sv
module i2c_page_slave
  import i2c_ps_pkg::*;
#(
  parameter int unsigned       SYNC_STAGES   = 2,
  parameter logic [4:0]        DEV_PREFIX    = 5'b01010,
  parameter int unsigned       PAGE_BYTES    = 8,
  parameter int unsigned       COMMIT_CYCLES = 2_500_000,
  parameter logic [7:0]        NV_ROW0_MASK  = 8'h09,
  parameter logic [ADDR_W-1:0] NV_LO         = 8'h80,
  parameter logic [ADDR_W-1:0] NV_HI         = 8'hC7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [1:0]        strap_i,
  input  logic              shadow_only_i,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [ADDR_W-1:0] reg_wdata_o,
  output logic [ADDR_W-1:0] reg_raddr_o,
  input  logic [ADDR_W-1:0] reg_rdata_i,
  output logic              busy_o,
  output logic              nv_we_o,
  output logic [ADDR_W-1:0] nv_addr_o,
  output logic [ADDR_W-1:0] nv_wdata_o
);
  localparam int unsigned PAGE_AW = $clog2(PAGE_BYTES);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  i2c_ps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  logic scl_unused;
  assign scl_unused = scl_s;

  i2c_ps_engine #(.DEV_PREFIX(DEV_PREFIX), .PAGE_AW(PAGE_AW)) u_engine (
    .clk_i, .rst_ni,
    .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_evt), .stop_i(stop_evt),
    .strap_i, .busy_i(busy_o), .rdata_i(reg_rdata_i),
    .sda_oe_o, .we_o(reg_we_o), .waddr_o(reg_addr_o), .wdata_o(reg_wdata_o),
    .raddr_o(reg_raddr_o)
  );

  i2c_ps_page #(
    .PAGE_BYTES(PAGE_BYTES), .COMMIT_CYCLES(COMMIT_CYCLES),
    .NV_ROW0_MASK(NV_ROW0_MASK), .NV_LO(NV_LO), .NV_HI(NV_HI)
  ) u_page (
    .clk_i, .rst_ni,
    .we_i(reg_we_o), .waddr_i(reg_addr_o), .wdata_i(reg_wdata_o),
    .shadow_only_i, .start_i(start_evt), .stop_i(stop_evt),
    .busy_o, .nv_we_o, .nv_addr_o, .nv_wdata_o
  );
endmodule

// File: rtl/i2c_page_slave_chk.sv
module i2c_page_slave_chk
  import i2c_ps_pkg::*;
#(
  parameter int unsigned       COMMIT_CYCLES = 2_500_000,
  parameter logic [7:0]        NV_ROW0_MASK  = 8'h09,
  parameter logic [ADDR_W-1:0] NV_LO         = 8'h80,
  parameter logic [ADDR_W-1:0] NV_HI         = 8'hC7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              reg_we_o,
  input logic              nv_we_o,
  input logic [ADDR_W-1:0] nv_addr_o
);
  int unsigned busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_cnt_q <= 0;
    else if (!busy_o) busy_cnt_q <= 0;
    else if (busy_cnt_q < COMMIT_CYCLES + 64) busy_cnt_q <= busy_cnt_q + 1;
  end

  AST_NV_IN_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_we_o |-> busy_o); // R6
  AST_NV_LOCATION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_we_o |-> nv_loc(nv_addr_o, NV_ROW0_MASK, NV_LO, NV_HI)); // R6
  AST_COMMIT_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_we_o |-> (busy_cnt_q >= COMMIT_CYCLES)); // R6
  AST_NO_WRITE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !busy_o); // R8
  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o); // R3
endmodule

bind i2c_page_slave i2c_page_slave_chk #(
  .COMMIT_CYCLES(COMMIT_CYCLES), .NV_ROW0_MASK(NV_ROW0_MASK), .NV_LO(NV_LO), .NV_HI(NV_HI)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .reg_we_o(reg_we_o),
  .nv_we_o(nv_we_o), .nv_addr_o(nv_addr_o)
);

// File: tb/test_i2c_page_slave.sv
module test_i2c_page_slave;
  localparam int COMMIT = 600;
  localparam int H      = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b00;
  logic       shadow = 1'b0;
  logic       sda_oe, reg_we, busy, nv_we;
  logic [7:0] reg_addr, reg_wdata, reg_raddr, reg_rdata, nv_addr, nv_wdata;
  logic       sda_bus;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_page_slave #(.COMMIT_CYCLES(COMMIT)) i_i2c_page_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_i(strap), .shadow_only_i(shadow),
    .reg_we_o(reg_we), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_raddr_o(reg_raddr), .reg_rdata_i(reg_rdata),
    .busy_o(busy), .nv_we_o(nv_we), .nv_addr_o(nv_addr), .nv_wdata_o(nv_wdata)
  );

  int checks = 0, fails = 0, nv_seen = 0;
  logic [15:0] exp_reg[$];
  logic [15:0] exp_nv[$];
  logic [7:0]  regfile [256];
  logic [7:0]  model [256];
  logic [7:0]  wbuf [16];
  logic [7:0]  nvb [8];
  logic [7:0]  nvv;
  logic [4:0]  nv_base;

  always_comb reg_rdata = regfile[reg_raddr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected strobes and compare
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) regfile[i] = 8'h00;
    end else begin
      if (reg_we) begin
        regfile[reg_addr] = reg_wdata;
        if (exp_reg.size() == 0) chk("R3 unexpected reg write", {reg_addr, reg_wdata}, 32'hFFFF_FFFF);
        else chk("R3 reg write", {reg_addr, reg_wdata}, exp_reg.pop_front());
      end
      if (nv_we) begin
        nv_seen++;
        if (exp_nv.size() == 0) chk("R6 unexpected nv write", {nv_addr, nv_wdata}, 32'hFFFF_FFFF);
        else chk("R6 nv write", {nv_addr, nv_wdata}, exp_nv.pop_front());
      end
    end
  end

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit is_nv(input logic [7:0] a);
    return a == 8'h00 || a == 8'h03 || (a >= 8'h80 && a <= 8'hC7);
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; wc(H); scl = 1'b1; wc(H); sda_m = 1'b0; wc(H); scl = 1'b0; wc(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wc(H); scl = 1'b1; wc(H); sda_m = 1'b1; wc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wc(H); scl = 1'b1; wc(H); scl = 1'b0; wc(2);
    end
    sda_m = 1'b1; wc(H); scl = 1'b1; wc(H/2); acked = ~sda_bus; wc(H/2); scl = 1'b0; wc(2);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wc(H); scl = 1'b1; wc(H/2); b = {b[6:0], sda_bus}; wc(H/2); scl = 1'b0; wc(2);
    end
    sda_m = ~give_ack; wc(H); scl = 1'b1; wc(H); scl = 1'b0; wc(2); sda_m = 1'b1;
  endtask

  task automatic commit_model();
    for (int s = 0; s < 8; s++)
      if (nvv[s]) exp_nv.push_back({nv_base, 3'(s), nvb[s]});
    nvv = '0;
  endtask

  task automatic wr_txn(input logic [7:0] dev, input logic [7:0] ma, input int n, input bit use_stop);
    bit ak;
    logic [7:0] a;
    bus_start();
    send_byte(dev, ak); chk("R2 device ack", ak, 1);
    send_byte(ma, ak);  chk("R3 address ack", ak, 1);
    a = ma;
    for (int i = 0; i < n; i++) begin
      exp_reg.push_back({a, wbuf[i]});
      model[a] = wbuf[i];
      if (is_nv(a) && !(shadow && a == 8'h00)) begin
        nvb[a[2:0]] = wbuf[i]; nvv[a[2:0]] = 1'b1; nv_base = a[7:3];
      end
      send_byte(wbuf[i], ak); chk("R3 data ack", ak, 1);
      a = {a[7:3], a[2:0] + 3'd1};
    end
    if (use_stop) begin
      commit_model();
      bus_stop();
    end
  endtask

  task automatic rd_txn(input logic [7:0] dev, input logic [7:0] ma, input int n);
    bit ak;
    logic [7:0] a, b;
    bus_start();
    send_byte(dev, ak); chk("R2 device ack", ak, 1);
    send_byte(ma, ak);  chk("R3 address ack", ak, 1);
    nvv = '0;
    bus_start();
    send_byte(dev | 8'h01, ak); chk("R2 read device ack", ak, 1);
    a = ma;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk("R5 read data", b, model[a]);
      a = a + 8'd1;
    end
    wc(4);
    chk("R5 released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk("R6 busy falls", busy, 0);
  endtask

  initial begin
    bit ak;
    logic [7:0] b;
    int base_cnt;
    nvv = '0; nv_base = '0;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    wc(5);
    chk("R1 sda released in reset", sda_oe, 0);
    rst_n = 1'b1;
    wc(5);
    chk("R1 sda released", sda_oe, 0);
    chk("R1 not busy", busy, 0);

    // R3/R10 volatile write, no commit
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2;
    wr_txn(8'h50, 8'h10, 2, 1);
    wc(10);
    chk("R10 no commit for volatile write", busy, 0);
    rd_txn(8'h50, 8'h10, 2);

    // R9 shadow bit: 00h filtered
    shadow = 1'b1;
    wbuf[0] = 8'h3C; wbuf[1] = 8'h44; wbuf[2] = 8'h55; wbuf[3] = 8'h66;
    base_cnt = nv_seen;
    wr_txn(8'h50, 8'h00, 4, 1);
    wc(10);
    chk("R6 busy after STOP", busy, 1);
    wait_idle();
    chk("R9 shadow_only keeps 00h out of commit", nv_seen - base_cnt, 1);
    shadow = 1'b0;
    wbuf[0] = 8'h7E;
    base_cnt = nv_seen;
    wr_txn(8'h50, 8'h00, 1, 1);
    wait_idle();
    chk("R9 00h committed without shadow_only", nv_seen - base_cnt, 1);

    // R5 full-range read wrap FFh -> 00h
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wr_txn(8'h50, 8'hFE, 2, 1);
    rd_txn(8'h50, 8'hFE, 3);

    // R4 page wrap with 10 bytes into an NV page
    for (int i = 0; i < 10; i++) wbuf[i] = 8'h10 + 8'(i);
    wr_txn(8'h50, 8'h84, 10, 1);
    wc(10);
    chk("R6 busy after page STOP", busy, 1);
    // R8 acknowledge polling during commit
    bus_start();
    send_byte(8'h50, ak); chk("R8 own address refused while busy", ak, 0);
    send_byte(8'h05, ak); chk("R8 following byte ignored", ak, 0);
    bus_stop();
    wait_idle();
    chk("R6 all page bytes committed", exp_nv.size(), 0);
    rd_txn(8'h50, 8'h80, 8);

    // R7 repeated START cancels commit
    wbuf[0] = 8'h5A;
    wr_txn(8'h50, 8'h90, 1, 0);
    nvv = '0;
    bus_start();
    send_byte(8'h51, ak); chk("R7 read after Sr ack", ak, 1);
    recv_byte(1'b0, b);
    chk("R7 read continues at counter", b, model[8'h91]);
    bus_stop();
    wc(20);
    chk("R7 no commit after Sr", busy, 0);

    // R2 strap decode and mismatch
    strap = 2'b10;
    bus_start();
    send_byte(8'h50, ak); chk("R2 mismatch NACK", ak, 0);
    send_byte(8'h20, ak); chk("R2 ignored byte", ak, 0);
    send_byte(8'h99, ak); chk("R2 ignored byte", ak, 0);
    bus_stop();
    wbuf[0] = 8'h42;
    wr_txn(8'h54, 8'h30, 1, 1);
    rd_txn(8'h54, 8'h30, 1);

    wc(50);
    chk("R3 reg queue drained", exp_reg.size(), 0);
    chk("R6 nv queue drained", exp_nv.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule